// File: doc/BRIEF.md
# Interrupt Priority and Vector Generator

This block decides which pending interrupt the CPU services next and produces the pair of addresses from which the core fetches the service routine's start address. It takes six sources. Reset and the software interrupt are non-maskable. The external pin, the timer, the serial communications interface and the serial peripheral interface are maskable. Each peripheral offers several status flags with their own enable bits, and all flags of one peripheral share a single vector.

The core presents an instruction-boundary strobe whenever it could begin interrupt processing. On that strobe the block arbitrates by fixed priority. It then raises a one-cycle take pulse, loads the vector address pair, and asks the core to set the global mask bit. A software-interrupt strobe from the instruction decoder records the maskable requests pending at that moment. Those requests are served ahead of the software interrupt, and requests that arrive later wait behind it. The external pin passes through a synchronizer and a falling-edge latch. When the level option is enabled, a pin held low also counts as a request.

Top module: `irq_vector_arbiter`

## Requirements
- R1: Asserting `reset_req_i` causes `take_o` to be 1 in the next cycle with `vec_hi_o`=16'h1FFE and `vec_lo_o`=16'h1FFF, whatever the values of `mask_i` and `boundary_i`.
- R2: Each source has its own vector pair, with `vec_lo_o` = `vec_hi_o`+1. The high addresses are: software interrupt 16'h1FFC, external pin 16'h1FFA, timer 16'h1FF8, serial communications 16'h1FF6, serial peripheral 16'h1FF4. After reset the outputs hold the reset pair.
- R3: The timer requests when any `tmr_flag_i[k] & tmr_en_i[k]` is 1. Bit 0 is input capture, bit 1 is output compare and bit 2 is overflow. A flag whose enable is 0 causes no request.
- R4: The serial communications interface requests when any `sci_flag_i[k] & sci_en_i[k]` is 1. Bit 0 is transmit buffer empty, bit 1 is transmit done, bit 2 is receive full, bit 3 is idle line and bit 4 is overrun.
- R5: The serial peripheral interface requests when any `spi_flag_i[k] & spi_en_i[k]` is 1. Bit 0 is transfer done and bit 1 is mode fault.
- R6: While `mask_i`=1, no maskable source is taken. The requests stay pending and are taken at a boundary after `mask_i` returns to 0.
- R7: A software interrupt fetched with `swi_fetch_i` is taken at the next boundary even when `mask_i`=1.
- R8: With `mask_i`=0, maskable requests that are pending when `swi_fetch_i` pulses are taken before the software interrupt. Requests that arrive after the fetch are taken after it.
- R9: Fixed priority, highest first: reset, software interrupt (subject to R8), external pin, timer, serial communications, serial peripheral.
- R10: Apart from reset, a decision is made only in a cycle with `boundary_i`=1. `take_o` and `mask_set_o` are then 1 for exactly the following cycle.
- R11: A falling edge on `ext_irq_n_i` is latched, so a low pulse lasting one clock is serviced later. Taking the external vector clears the latch.
- R12: With the level option (`EXT_LEVEL`=1, the default), a pin that is still low after its vector is taken requests again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reset_req_i | input | 1 | Reset-source request, non-maskable |
| mask_i | input | 1 | Global interrupt mask bit |
| swi_fetch_i | input | 1 | Software-interrupt fetch strobe |
| boundary_i | input | 1 | Instruction-boundary strobe |
| ext_irq_n_i | input | 1 | External interrupt pin, active low, asynchronous |
| tmr_flag_i | input | 3 | Timer status flags |
| tmr_en_i | input | 3 | Timer flag enables |
| sci_flag_i | input | 5 | Serial communications status flags |
| sci_en_i | input | 5 | Serial communications flag enables |
| spi_flag_i | input | 2 | Serial peripheral status flags |
| spi_en_i | input | 2 | Serial peripheral flag enables |
| take_o | output | 1 | One-cycle take-interrupt pulse |
| vec_hi_o | output | 16 | Address of the vector high byte |
| vec_lo_o | output | 16 | Address of the vector low byte |
| mask_set_o | output | 1 | Request to set the mask bit |

## Verification
A table of flag and enable patterns drives each peripheral one bit at a time and then several peripherals at once, with the mask both clear and set. It separates three kinds of fault: an error in the per-flag enable gating, an error in the grouping of flags onto their shared vector, and an inverted priority between peripherals. Directed sequences follow. One interleaves a software-interrupt fetch with requests arriving before and after it, which exposes a wrong ordering rule. One fetches with the mask set, which shows whether the software interrupt ignores the mask. Short and held pulses on the external pin tell edge latching apart from level detection. Pattern runs without a boundary strobe show whether arbitration waits for that strobe.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

  localparam int N_SRC      = 6;
  localparam int N_MASKABLE = 4;

  localparam int SRC_RST = 0;
  localparam int SRC_SWI = 1;
  localparam int SRC_EXT = 2;
  localparam int SRC_TMR = 3;
  localparam int SRC_SCI = 4;
  localparam int SRC_SPI = 5;

  // High-byte address of the vector for a source index; the pairs descend by two.
  function automatic logic [15:0] vec_addr(input logic [15:0] top, input int idx);
    return top - 16'(2 * idx);
  endfunction

endpackage

// File: rtl/irqv_group.sv
module irqv_group #(
  parameter int N = 3
) (
  input  logic [N-1:0] flags,
  input  logic [N-1:0] en,
  output logic         req
);

  logic [N-1:0] hit;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_hit
      assign hit[g] = flags[g] & en[g];
    end
  endgenerate

  assign req = |hit;

endmodule

// File: rtl/irqv_ext_latch.sv
module irqv_ext_latch #(
  parameter int SYNC_STAGES = 2,
  parameter bit LEVEL_MODE  = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  input  logic clr,
  output logic req
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   latch_q;
  logic                   lvl;
  logic                   fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign lvl  = sync_q[SYNC_STAGES-1];
  assign fall = prev_q & ~lvl;

  // A new edge wins over a clear in the same cycle so no pulse is lost.
  always_ff @(posedge clk) begin
    if (rst)       latch_q <= 1'b0;
    else if (fall) latch_q <= 1'b1;
    else if (clr)  latch_q <= 1'b0;
  end

  generate
    if (LEVEL_MODE) begin : g_level
      assign req = latch_q | ~lvl;
    end else begin : g_edge
      assign req = latch_q;
    end
  endgenerate

  AST_LATCH_STICKY: assert property (@(posedge clk) disable iff (rst)
    latch_q && !clr |=> latch_q); // R11

endmodule

// File: rtl/irqv_select.sv
module irqv_select
  import irqv_pkg::*;
(
  input  logic                  reset_req,
  input  logic                  boundary,
  input  logic                  mask,
  input  logic                  swi_pend,
  input  logic [N_MASKABLE-1:0] live,
  input  logic [N_MASKABLE-1:0] snap,
  output logic [N_SRC-1:0]      grant,
  output logic                  fire
);

  logic [N_MASKABLE-1:0] early;
  logic [N_MASKABLE-1:0] open_req;

  assign early    = snap & live & {N_MASKABLE{~mask}};
  assign open_req = live & {N_MASKABLE{~mask}};

  always_comb begin
    logic found;
    grant = '0;
    found = 1'b0;
    if (reset_req) begin
      grant[SRC_RST] = 1'b1;
    end else if (boundary) begin
      if (swi_pend) begin
        for (int i = 0; i < N_MASKABLE; i++) begin
          if (early[i] && !found) begin
            grant[SRC_EXT + i] = 1'b1;
            found = 1'b1;
          end
        end
        if (!found) grant[SRC_SWI] = 1'b1;
      end else begin
        for (int i = 0; i < N_MASKABLE; i++) begin
          if (open_req[i] && !found) begin
            grant[SRC_EXT + i] = 1'b1;
            found = 1'b1;
          end
        end
      end
    end
  end

  assign fire = |grant;

  always_comb begin
    AST_GRANT_ONEHOT: assert ($onehot0(grant)); // R9
  end

endmodule

// File: rtl/irq_vector_arbiter.sv
module irq_vector_arbiter
  import irqv_pkg::*;
#(
  parameter int          ADDR_W      = 16,
  parameter logic [15:0] VEC_TOP     = 16'h1FFE,
  parameter int          TMR_N       = 3,
  parameter int          SCI_N       = 5,
  parameter int          SPI_N       = 2,
  parameter int          SYNC_STAGES = 2,
  parameter bit          EXT_LEVEL   = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reset_req_i,
  input  logic              mask_i,
  input  logic              swi_fetch_i,
  input  logic              boundary_i,
  input  logic              ext_irq_n_i,
  input  logic [TMR_N-1:0]  tmr_flag_i,
  input  logic [TMR_N-1:0]  tmr_en_i,
  input  logic [SCI_N-1:0]  sci_flag_i,
  input  logic [SCI_N-1:0]  sci_en_i,
  input  logic [SPI_N-1:0]  spi_flag_i,
  input  logic [SPI_N-1:0]  spi_en_i,
  output logic              take_o,
  output logic [ADDR_W-1:0] vec_hi_o,
  output logic [ADDR_W-1:0] vec_lo_o,
  output logic              mask_set_o
);

  localparam logic [ADDR_W-1:0] RST_HI = ADDR_W'(VEC_TOP);
  localparam logic [ADDR_W-1:0] SWI_HI = ADDR_W'(vec_addr(VEC_TOP, SRC_SWI));

  logic [N_MASKABLE-1:0] live;
  logic [N_MASKABLE-1:0] snap_q;
  logic [N_SRC-1:0]      grant;
  logic                  fire;
  logic                  swi_pend_q;
  logic                  ext_clr;
  logic                  nonmask_take;
  logic [ADDR_W-1:0]     next_hi;

  irqv_ext_latch #(
    .SYNC_STAGES (SYNC_STAGES),
    .LEVEL_MODE  (EXT_LEVEL)
  ) u_ext (
    .clk   (clk),
    .rst   (rst),
    .pin_n (ext_irq_n_i),
    .clr   (ext_clr),
    .req   (live[0])
  );

  irqv_group #(.N(TMR_N)) u_tmr (.flags(tmr_flag_i), .en(tmr_en_i), .req(live[1]));
  irqv_group #(.N(SCI_N)) u_sci (.flags(sci_flag_i), .en(sci_en_i), .req(live[2]));
  irqv_group #(.N(SPI_N)) u_spi (.flags(spi_flag_i), .en(spi_en_i), .req(live[3]));

  irqv_select u_sel (
    .reset_req (reset_req_i),
    .boundary  (boundary_i),
    .mask      (mask_i),
    .swi_pend  (swi_pend_q),
    .live      (live),
    .snap      (snap_q),
    .grant     (grant),
    .fire      (fire)
  );

  assign ext_clr      = grant[SRC_EXT];
  assign nonmask_take = grant[SRC_RST] | grant[SRC_SWI];

  always_comb begin
    next_hi = RST_HI;
    for (int i = 0; i < N_SRC; i++) begin
      if (grant[i]) next_hi = ADDR_W'(vec_addr(VEC_TOP, i));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      take_o     <= 1'b0;
      mask_set_o <= 1'b0;
      vec_hi_o   <= RST_HI;
      vec_lo_o   <= RST_HI + 1'b1;
    end else begin
      take_o     <= fire;
      mask_set_o <= fire;
      if (fire) begin
        vec_hi_o <= next_hi;
        vec_lo_o <= next_hi + 1'b1;
      end
    end
  end

  // Software-interrupt bookkeeping: pending flag and snapshot of earlier requests.
  always_ff @(posedge clk) begin
    if (rst) begin
      swi_pend_q <= 1'b0;
      snap_q     <= '0;
    end else if (fire && nonmask_take) begin
      swi_pend_q <= 1'b0;
      snap_q     <= '0;
    end else if (swi_fetch_i && !swi_pend_q) begin
      swi_pend_q <= 1'b1;
      snap_q     <= live & {N_MASKABLE{~mask_i}};
    end else begin
      snap_q     <= snap_q & live & ~grant[N_SRC-1:SRC_EXT];
    end
  end

  AST_RESET_WINS: assert property (@(posedge clk) disable iff (rst)
    reset_req_i |=> take_o && vec_hi_o == RST_HI); // R1

  AST_ONLY_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    take_o |-> $past(boundary_i || reset_req_i)); // R10

  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    take_o && $past(mask_i) && !$past(reset_req_i) |-> vec_hi_o == SWI_HI); // R6

  AST_VEC_PAIR: assert property (@(posedge clk) disable iff (rst)
    take_o |-> vec_lo_o == vec_hi_o + 1'b1); // R2

endmodule

// File: tb/test_irq_vector_arbiter.sv
module test_irq_vector_arbiter;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reset_req = 1'b0;
  logic        mask = 1'b0;
  logic        swi_fetch = 1'b0;
  logic        boundary = 1'b0;
  logic        ext_n = 1'b1;
  logic [2:0]  tmr_f = '0, tmr_e = '0;
  logic [4:0]  sci_f = '0, sci_e = '0;
  logic [1:0]  spi_f = '0, spi_e = '0;
  logic        take, mset;
  logic [15:0] vhi, vlo;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  irq_vector_arbiter i_irq_vector_arbiter (
    .clk(clk), .rst(rst), .reset_req_i(reset_req), .mask_i(mask),
    .swi_fetch_i(swi_fetch), .boundary_i(boundary), .ext_irq_n_i(ext_n),
    .tmr_flag_i(tmr_f), .tmr_en_i(tmr_e), .sci_flag_i(sci_f), .sci_en_i(sci_e),
    .spi_flag_i(spi_f), .spi_en_i(spi_e), .take_o(take), .vec_hi_o(vhi),
    .vec_lo_o(vlo), .mask_set_o(mset)
  );

  typedef struct packed {
    logic        m;
    logic [2:0]  tf, te;
    logic [4:0]  sf, se;
    logic [1:0]  pf, pe;
    logic        tk;
    logic [15:0] hi;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 3'b001, 3'b001, 5'b00000, 5'b00000, 2'b00, 2'b00, 1'b1, 16'h1FF8}, // R3 capture
    '{1'b0, 3'b100, 3'b100, 5'b00000, 5'b00000, 2'b00, 2'b00, 1'b1, 16'h1FF8}, // R3 overflow
    '{1'b0, 3'b010, 3'b101, 5'b00000, 5'b00000, 2'b00, 2'b00, 1'b0, 16'h0000}, // R3 no enable
    '{1'b0, 3'b000, 3'b000, 5'b10000, 5'b10000, 2'b00, 2'b00, 1'b1, 16'h1FF6}, // R4 overrun
    '{1'b0, 3'b000, 3'b000, 5'b00001, 5'b11111, 2'b00, 2'b00, 1'b1, 16'h1FF6}, // R4 tx empty
    '{1'b0, 3'b000, 3'b000, 5'b11111, 5'b00000, 2'b00, 2'b00, 1'b0, 16'h0000}, // R4 no enable
    '{1'b0, 3'b000, 3'b000, 5'b00000, 5'b00000, 2'b01, 2'b01, 1'b1, 16'h1FF4}, // R5 done
    '{1'b0, 3'b000, 3'b000, 5'b00000, 5'b00000, 2'b10, 2'b10, 1'b1, 16'h1FF4}, // R5 fault
    '{1'b0, 3'b010, 3'b010, 5'b00001, 5'b00001, 2'b01, 2'b01, 1'b1, 16'h1FF8}, // R9
    '{1'b0, 3'b000, 3'b000, 5'b00100, 5'b00100, 2'b11, 2'b11, 1'b1, 16'h1FF6}, // R9
    '{1'b1, 3'b111, 3'b111, 5'b00000, 5'b00000, 2'b00, 2'b00, 1'b0, 16'h0000}, // R6
    '{1'b1, 3'b000, 3'b000, 5'b00000, 5'b00000, 2'b10, 2'b10, 1'b0, 16'h0000}  // R6
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic strobe();
    @(negedge clk) boundary = 1'b1;
    @(negedge clk) boundary = 1'b0;
  endtask

  task automatic fetch_swi();
    @(negedge clk) swi_fetch = 1'b1;
    @(negedge clk) swi_fetch = 1'b0;
  endtask

  task automatic clear_flags();
    tmr_f = '0; tmr_e = '0; sci_f = '0; sci_e = '0; spi_f = '0; spi_e = '0; mask = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R2 reset take", 32'(take), 32'd0);
    chk("R2 reset mask_set", 32'(mset), 32'd0);
    chk("R2 reset vec_hi", 32'(vhi), 32'h1FFE);
    chk("R2 reset vec_lo", 32'(vlo), 32'h1FFF);

    for (int v = 0; v < NV; v++) begin
      mask = TBL[v].m; tmr_f = TBL[v].tf; tmr_e = TBL[v].te;
      sci_f = TBL[v].sf; sci_e = TBL[v].se; spi_f = TBL[v].pf; spi_e = TBL[v].pe;
      strobe();
      chk($sformatf("R3/R4/R5/R6/R9 vec %0d take", v), 32'(take), 32'(TBL[v].tk));
      if (TBL[v].tk) begin
        chk($sformatf("R2 vec %0d hi", v), 32'(vhi), 32'(TBL[v].hi));
        chk($sformatf("R10 vec %0d mask_set", v), 32'(mset), 32'd1);
      end
      clear_flags();
      @(negedge clk);
    end

    // R10: pending request without boundary is not taken; take lasts one cycle
    tmr_f = 3'b001; tmr_e = 3'b001;
    repeat (3) @(negedge clk);
    chk("R10 no boundary", 32'(take), 32'd0);
    strobe();
    chk("R10 taken", 32'(take), 32'd1);
    @(negedge clk);
    chk("R10 single pulse", 32'(take), 32'd0);
    chk("R10 mask_set pulse", 32'(mset), 32'd0);

    // R6: masked request held, then taken once mask clears
    mask = 1'b1;
    strobe();
    chk("R6 masked", 32'(take), 32'd0);
    mask = 1'b0;
    strobe();
    chk("R6 unmasked take", 32'(take), 32'd1);
    chk("R6 unmasked vec", 32'(vhi), 32'h1FF8);
    clear_flags();

    // R7: software interrupt under mask
    mask = 1'b1; sci_f = 5'b00100; sci_e = 5'b00100;
    fetch_swi();
    strobe();
    chk("R7 swi take", 32'(take), 32'd1);
    chk("R7 swi vec_hi", 32'(vhi), 32'h1FFC);
    chk("R7 swi vec_lo", 32'(vlo), 32'h1FFD);
    clear_flags();
    @(negedge clk);

    // R8: earlier timer first, then SWI, then later SCI
    tmr_f = 3'b010; tmr_e = 3'b010;
    fetch_swi();
    sci_f = 5'b00010; sci_e = 5'b00010;
    strobe();
    chk("R8 earlier request first", 32'(vhi), 32'h1FF8);
    tmr_f = '0;
    strobe();
    chk("R8 swi second", 32'(vhi), 32'h1FFC);
    strobe();
    chk("R8 later request last", 32'(vhi), 32'h1FF6);
    clear_flags();
    @(negedge clk);

    // R11 + R9: short pulse latched, beats the timer, then cleared
    tmr_f = 3'b100; tmr_e = 3'b100;
    @(negedge clk) ext_n = 1'b0;
    @(negedge clk) ext_n = 1'b1;
    repeat (4) @(negedge clk);
    strobe();
    chk("R11 R9 ext over timer", 32'(vhi), 32'h1FFA);
    strobe();
    chk("R11 latch cleared", 32'(vhi), 32'h1FF8);
    clear_flags();
    strobe();
    chk("R11 nothing left", 32'(take), 32'd0);

    // R12: held low pin requests again
    @(negedge clk) ext_n = 1'b0;
    repeat (4) @(negedge clk);
    strobe();
    chk("R12 first take", 32'(vhi), 32'h1FFA);
    strobe();
    chk("R12 level retake", 32'(take), 32'd1);
    ext_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset source, masked and no boundary
    mask = 1'b1;
    @(negedge clk) reset_req = 1'b1;
    @(negedge clk) reset_req = 1'b0;
    chk("R1 reset take", 32'(take), 32'd1);
    chk("R1 reset vec", 32'(vhi), 32'h1FFE);
    chk("R1 reset vec lo", 32'(vlo), 32'h1FFF);
    mask = 1'b0;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule